// File: doc/BRIEF.md
# Per-Slot Uplink Power Sequencer

This block decides, cycle by cycle, the power code sent to the transmit gain element during a multislot uplink frame. At every slot boundary it samples a network-imposed ceiling and an open-loop level derived from received-signal measurements. It then picks the weaker of the two, or, in compliance-test mode, a forced strong/weak/strong pattern. The block shapes each burst with a linear ramp. It rises from the off code to the target at the start of a slot. It falls back to the off code at the end of the last slot of a contiguous run. It steps directly between targets when two active slots sit side by side.

Slot timing comes from two strobes: a slot strobe at every slot boundary and a frame strobe that also marks slot 0. An eight-bit activity mask, captured at the frame strobe, says which slots carry a burst. Any mask from one active slot up to all eight is accepted. Power codes are 5 bits wide: code 0 is the strongest level and code 31 means the transmitter is off, so a weaker level is a larger code.

Top module: `tx_pwr_seq`

## Requirements
- R1: In normal mode an active slot settles on the larger code of `net_max_lvl` and `ol_lvl`, which is the weaker of the two levels.
- R2: In test mode the active slots of a frame are counted from the frame strobe. The first settles on `net_max_lvl`, the second on code 19, and every later one on `net_max_lvl` again. `ol_lvl` is ignored.
- R3: Level inputs are sampled only on the boundary edge. A change in the middle of a slot leaves that slot's code unchanged and takes effect from the next slot.
- R4: An active slot that starts at code 31 ramps in 4 cycles. On cycle c (c = 0..3 after the boundary edge) the code is `from + trunc((to - from) * (c + 1) / 4)`, and the phase is RISE (1).
- R5: An active slot whose following slot (mask bit (index + 1) mod 8) is clear ramps down over its last 4 cycles with the same formula. It reaches code 31 on the last cycle, in phase FALL (3).
- R6: Adjacent active slots with different targets move from the old target to the new one over 4 cycles, in phase STEP (4), without passing through code 31. With equal targets the code stays constant.
- R7: An inactive slot holds code 31 in phase OFF (0) with `burst_on` low. If it begins at a non-off code (the mask changed at a frame strobe), it first ramps to 31 over 4 cycles in phase FALL.
- R8: All eight slots active gives a continuous burst. No ramp-down occurs between slot 7 and slot 0 of the next frame.
- R9: After reset the code is 31, the phase is OFF and `burst_on` is low. The mask is captured only at a frame strobe, so slot strobes before the first frame strobe keep the output off.
- R10: Outside ramps the phase is FLAT (2) when the code is not 31, and OFF otherwise. `burst_on` equals the mask bit of the current slot, where slot index 0 is set by the frame strobe and each slot strobe advances it by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_strb | input | 1 | One-cycle pulse at each slot boundary |
| frame_strb | input | 1 | One-cycle pulse at the boundary of slot 0, given with slot_strb |
| slot_mask | input | 8 | Active-slot mask, bit i for slot i, captured at frame_strb |
| test_mode | input | 1 | Selects the forced compliance pattern |
| net_max_lvl | input | 5 | Network ceiling power code |
| ol_lvl | input | 5 | Open-loop power code from receive measurements |
| pwr_code | output | 5 | Power code to the gain element (0 strongest, 31 off) |
| ramp_phase | output | 3 | 0 OFF, 1 RISE, 2 FLAT, 3 FALL, 4 STEP |
| burst_on | output | 1 | Current slot is active |

## Verification
The main function is exercised with an isolated single slot, each input in turn acting as the limiting level, a contiguous three-slot run with a mid-slot change of the open-loop level, test-mode frames with dense and sparse masks, and full-duty frames followed by an empty frame. The isolated slot separates the rise and fall ramps from flat holding. The contiguous run tells a direct step from a ramp through off, and shows that inputs are sampled only at boundaries. The test-mode frames check that the slot ordinal restarts each frame. The full-duty and empty-frame sequence exposes any spurious ramp at the frame wrap, as well as the ramp-down that a mask change forces at the start of a slot.

// File: rtl/tps_pkg.sv
package tps_pkg;

    // Envelope phase reported beside the power code
    typedef enum logic [2:0] {
        PH_OFF  = 3'd0,
        PH_RISE = 3'd1,
        PH_FLAT = 3'd2,
        PH_FALL = 3'd3,
        PH_STEP = 3'd4
    } tps_phase_e;

endpackage

// File: rtl/tps_slot_timer.sv
module tps_slot_timer #(
    parameter int NUM_SLOTS = 8,
    parameter int SLOT_LEN  = 32,
    parameter int IDX_W     = 3,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_strb,
    input  logic             frame_strb,
    output logic             bnd,
    output logic [IDX_W-1:0] idx_nxt,
    output logic [IDX_W-1:0] follow_idx,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SLOT_LEN - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d        = t_q;
        bnd        = slot_strb | frame_strb;
        follow_idx = (t_q.idx == LAST_IDX) ? '0 : t_q.idx + 1'b1;
        idx_nxt    = frame_strb ? '0 : follow_idx;
        if (bnd) begin
            t_d.idx = idx_nxt;
            t_d.cnt = '0;
        end else if (t_q.cnt != LAST_CNT) begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.idx <= LAST_IDX;
            t_q.cnt <= LAST_CNT;
        end else begin
            t_q <= t_d;
        end
    end

    assign cnt_q = t_q.cnt;

endmodule

// File: rtl/tps_level_sel.sv
module tps_level_sel #(
    parameter int CODE_W   = 5,
    parameter int MIN_CODE = 19
) (
    input  logic [CODE_W-1:0] net_max_lvl,
    input  logic [CODE_W-1:0] ol_lvl,
    input  logic              test_mode,
    input  logic [1:0]        ord,
    output logic [CODE_W-1:0] lvl
);

    localparam logic [CODE_W-1:0] WEAK_V = CODE_W'(MIN_CODE);

    logic [CODE_W-1:0] weaker;

    always_comb begin
        // larger code is lower power
        weaker = (net_max_lvl > ol_lvl) ? net_max_lvl : ol_lvl;
        if (!test_mode) begin
            lvl = weaker;
        end else if (ord == 2'd1) begin
            lvl = WEAK_V;
        end else begin
            lvl = net_max_lvl;
        end
    end

endmodule

// File: rtl/tps_ramp_interp.sv
module tps_ramp_interp #(
    parameter int CODE_W     = 5,
    parameter int RAMP_STEPS = 4,
    parameter int STEP_W     = 3
) (
    input  logic [CODE_W-1:0] from_c,
    input  logic [CODE_W-1:0] to_c,
    input  logic [STEP_W-1:0] step,
    output logic [CODE_W-1:0] code
);

    int f_i, t_i, acc;

    always_comb begin
        f_i  = int'(from_c);
        t_i  = int'(to_c);
        acc  = f_i + ((t_i - f_i) * int'(step)) / RAMP_STEPS;
        code = CODE_W'(acc);
    end

endmodule

// File: rtl/tx_pwr_seq.sv
module tx_pwr_seq #(
    parameter int CODE_W     = 5,
    parameter int NUM_SLOTS  = 8,
    parameter int SLOT_LEN   = 32,
    parameter int RAMP_STEPS = 4,
    parameter int OFF_CODE   = 31,
    parameter int MIN_CODE   = 19
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slot_strb,
    input  logic                 frame_strb,
    input  logic [NUM_SLOTS-1:0] slot_mask,
    input  logic                 test_mode,
    input  logic [CODE_W-1:0]    net_max_lvl,
    input  logic [CODE_W-1:0]    ol_lvl,
    output logic [CODE_W-1:0]    pwr_code,
    output logic [2:0]           ramp_phase,
    output logic                 burst_on
);

    import tps_pkg::*;

    localparam int IDX_W  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam int CNT_W  = $clog2(SLOT_LEN);
    localparam int STEP_W = $clog2(RAMP_STEPS + 1);

    localparam logic [CODE_W-1:0] OFF_V     = CODE_W'(OFF_CODE);
    localparam logic [CNT_W-1:0]  DN_CNT    = CNT_W'(SLOT_LEN - RAMP_STEPS - 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(RAMP_STEPS);
    localparam logic [STEP_W-1:0] ONE_STEP  = STEP_W'(1);

    typedef struct packed {
        logic [CODE_W-1:0]    code;
        tps_phase_e           phase;
        logic [CODE_W-1:0]    from;
        logic [CODE_W-1:0]    to;
        logic [STEP_W-1:0]    rs;
        logic                 act;
        logic [NUM_SLOTS-1:0] mask;
        logic [1:0]           ord;
    } st_t;

    localparam st_t ST_RST = '{
        code:  OFF_V,
        phase: PH_OFF,
        from:  OFF_V,
        to:    OFF_V,
        rs:    '0,
        act:   1'b0,
        mask:  '0,
        ord:   '0
    };

    st_t s_d, s_q;

    // slot timing
    logic             bnd;
    logic [IDX_W-1:0] idx_nxt;
    logic [IDX_W-1:0] follow_idx;
    logic [CNT_W-1:0] cnt_q;

    tps_slot_timer #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_LEN  (SLOT_LEN),
        .IDX_W     (IDX_W),
        .CNT_W     (CNT_W)
    ) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_strb  (slot_strb),
        .frame_strb (frame_strb),
        .bnd        (bnd),
        .idx_nxt    (idx_nxt),
        .follow_idx (follow_idx),
        .cnt_q      (cnt_q)
    );

    // view of the frame as seen on this edge
    logic [NUM_SLOTS-1:0] eff_mask;
    logic [1:0]           ord_base;

    always_comb begin : frame_view
        eff_mask = frame_strb ? slot_mask : s_q.mask;
        ord_base = frame_strb ? 2'd0 : s_q.ord;
    end

    logic [CODE_W-1:0] lvl_sel;

    tps_level_sel #(
        .CODE_W   (CODE_W),
        .MIN_CODE (MIN_CODE)
    ) i_level (
        .net_max_lvl (net_max_lvl),
        .ol_lvl      (ol_lvl),
        .test_mode   (test_mode),
        .ord         (ord_base),
        .lvl         (lvl_sel)
    );

    // ramp request selection
    logic              new_act;
    logic [CODE_W-1:0] new_tgt;
    logic              follow_act;
    logic              dn_trig;
    logic [CODE_W-1:0] r_from;
    logic [CODE_W-1:0] r_to;
    logic [STEP_W-1:0] r_step;

    always_comb begin : req_sel
        new_act    = eff_mask[idx_nxt];
        new_tgt    = new_act ? lvl_sel : OFF_V;
        follow_act = s_q.mask[follow_idx];
        dn_trig    = !bnd && s_q.act && !follow_act
                     && (cnt_q == DN_CNT) && (s_q.code != OFF_V);
        if (bnd) begin
            r_from = s_q.code;
            r_to   = new_tgt;
            r_step = ONE_STEP;
        end else if (dn_trig) begin
            r_from = s_q.code;
            r_to   = OFF_V;
            r_step = ONE_STEP;
        end else begin
            r_from = s_q.from;
            r_to   = s_q.to;
            r_step = s_q.rs + 1'b1;
        end
    end

    logic [CODE_W-1:0] ramp_code;

    tps_ramp_interp #(
        .CODE_W     (CODE_W),
        .RAMP_STEPS (RAMP_STEPS),
        .STEP_W     (STEP_W)
    ) i_interp (
        .from_c (r_from),
        .to_c   (r_to),
        .step   (r_step),
        .code   (ramp_code)
    );

    always_comb begin : nxt_state
        s_d = s_q;
        if (bnd) begin
            s_d.mask = eff_mask;
            s_d.act  = new_act;
            if (new_act) begin
                s_d.ord = (ord_base == 2'd3) ? ord_base : ord_base + 1'b1;
            end else begin
                s_d.ord = ord_base;
            end
            s_d.from = s_q.code;
            s_d.to   = new_tgt;
            if (s_q.code == new_tgt) begin
                s_d.rs    = '0;
                s_d.phase = (new_tgt == OFF_V) ? PH_OFF : PH_FLAT;
            end else begin
                s_d.rs   = ONE_STEP;
                s_d.code = ramp_code;
                if (s_q.code == OFF_V) begin
                    s_d.phase = PH_RISE;
                end else if (new_tgt == OFF_V) begin
                    s_d.phase = PH_FALL;
                end else begin
                    s_d.phase = PH_STEP;
                end
            end
        end else if (dn_trig) begin
            s_d.from  = s_q.code;
            s_d.to    = OFF_V;
            s_d.rs    = ONE_STEP;
            s_d.code  = ramp_code;
            s_d.phase = PH_FALL;
        end else if (s_q.rs != '0) begin
            if (s_q.rs == LAST_STEP) begin
                s_d.rs    = '0;
                s_d.phase = (s_q.code == OFF_V) ? PH_OFF : PH_FLAT;
            end else begin
                s_d.rs   = s_q.rs + 1'b1;
                s_d.code = ramp_code;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= ST_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign pwr_code   = s_q.code;
    assign ramp_phase = s_q.phase;
    assign burst_on   = s_q.act;

endmodule

// File: rtl/tx_pwr_seq_chk.sv
module tx_pwr_seq_chk #(
    parameter int CODE_W     = 5,
    parameter int RAMP_STEPS = 4,
    parameter int OFF_CODE   = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] pwr_code,
    input logic [2:0]        ramp_phase,
    input logic              burst_on
);

    localparam logic [CODE_W-1:0] OFF_V = CODE_W'(OFF_CODE);
    localparam int RUN_W = $clog2(RAMP_STEPS + 2) + 1;

    logic             in_ramp;
    logic [2:0]       ph_prev;
    logic [RUN_W-1:0] run_len;

    assign in_ramp = (ramp_phase == 3'd1) || (ramp_phase == 3'd3)
                     || (ramp_phase == 3'd4);

    // length of the current run of one ramp phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_prev <= 3'd0;
            run_len <= '0;
        end else begin
            ph_prev <= ramp_phase;
            if (!in_ramp) begin
                run_len <= '0;
            end else if (ramp_phase == ph_prev && run_len != '1) begin
                run_len <= run_len + 1'b1;
            end else if (ramp_phase != ph_prev) begin
                run_len <= RUN_W'(1);
            end
        end
    end

    a_r10_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_phase <= 3'd4);

    a_r7_off_phase_code: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_phase == 3'd0) |-> (pwr_code == OFF_V));

    a_r7_idle_slot_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_on && ramp_phase != 3'd3) |-> (pwr_code == OFF_V));

    a_r10_flat_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_phase == 3'd2 && $past(ramp_phase) == 3'd2) |-> $stable(pwr_code));

    a_r4_rise_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_phase == 3'd1 && $past(ramp_phase) == 3'd1)
        |-> (pwr_code <= $past(pwr_code)));

    a_r5_fall_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_phase == 3'd3 && $past(ramp_phase) == 3'd3)
        |-> (pwr_code >= $past(pwr_code)));

    a_r6_step_not_off: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_phase == 3'd4) |-> (pwr_code != OFF_V));

    a_r4_ramp_len: assert property (@(posedge clk) disable iff (!rst_n)
        int'(run_len) <= RAMP_STEPS);

endmodule

bind tx_pwr_seq tx_pwr_seq_chk #(
    .CODE_W     (CODE_W),
    .RAMP_STEPS (RAMP_STEPS),
    .OFF_CODE   (OFF_CODE)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_code   (pwr_code),
    .ramp_phase (ramp_phase),
    .burst_on   (burst_on)
);

// File: tb/test_tx_pwr_seq.sv
module test_tx_pwr_seq;

    localparam int CLK_PERIOD = 10;
    localparam int SLOT_LEN   = 32;
    localparam int RAMP       = 4;
    localparam int OFFC       = 31;
    localparam int WEAKC      = 19;

    logic       clk;
    logic       rst_n;
    logic       slot_strb;
    logic       frame_strb;
    logic [7:0] slot_mask;
    logic       test_mode;
    logic [4:0] net_max_lvl;
    logic [4:0] ol_lvl;
    logic [4:0] pwr_code;
    logic [2:0] ramp_phase;
    logic       burst_on;

    tx_pwr_seq i_tx_pwr_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_strb   (slot_strb),
        .frame_strb  (frame_strb),
        .slot_mask   (slot_mask),
        .test_mode   (test_mode),
        .net_max_lvl (net_max_lvl),
        .ol_lvl      (ol_lvl),
        .pwr_code    (pwr_code),
        .ramp_phase  (ramp_phase),
        .burst_on    (burst_on)
    );

    int n_chk;
    int n_err;
    int last_code;
    int exp_ord;
    int cur_net;
    int cur_ol;

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check_val(input string req, input string what,
                             input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s %s [%s]: actual %0d expected %0d",
                     req, what, tag, got, exp);
        end
    endtask

    function automatic int ramp_val(input int f, input int t, input int i);
        return f + ((t - f) * i) / RAMP;
    endfunction

    task automatic set_levels(input int net, input int ol);
        net_max_lvl = 5'(net);
        ol_lvl      = 5'(ol);
        cur_net     = net;
        cur_ol      = ol;
    endtask

    // one slot, entered just after a falling edge
    task automatic run_slot(input int s, input logic [7:0] drv_mask,
                            input logic [7:0] mdl_mask, input bit frm,
                            input bit tm, input int chg_cyc, input int ol_new,
                            input string tag);
        int  tgt, from, lvl, ec, ep;
        bit  act, nxt_act, up;
        string req;
        slot_strb  = 1'b1;
        frame_strb = frm;
        slot_mask  = drv_mask;
        test_mode  = tm;
        if (frm) exp_ord = 0;
        act     = mdl_mask[s];
        nxt_act = mdl_mask[(s + 1) % 8];
        lvl     = OFFC;
        if (act) begin
            if (tm) lvl = (exp_ord == 1) ? WEAKC : cur_net;
            else    lvl = (cur_net > cur_ol) ? cur_net : cur_ol;
            exp_ord++;
        end
        tgt  = act ? lvl : OFFC;
        from = last_code;
        up   = (from != tgt);
        for (int c = 0; c < SLOT_LEN; c++) begin
            @(negedge clk);
            if (c == 0) begin
                slot_strb  = 1'b0;
                frame_strb = 1'b0;
            end
            if (up && c < RAMP) begin
                ec = ramp_val(from, tgt, c + 1);
                if (from == OFFC) begin ep = 1; req = "R4"; end
                else if (tgt == OFFC) begin ep = 3; req = "R7"; end
                else begin ep = 4; req = "R6"; end
            end else if (act && !nxt_act && c >= SLOT_LEN - RAMP) begin
                ec  = ramp_val(tgt, OFFC, c - (SLOT_LEN - RAMP) + 1);
                ep  = 3;
                req = "R5";
            end else begin
                ec  = tgt;
                ep  = (tgt == OFFC) ? 0 : 2;
                req = act ? (tm ? "R2" : "R1") : "R7";
            end
            check_val(req, "pwr_code", tag, int'(pwr_code), ec);
            check_val("R10", "ramp_phase", tag, int'(ramp_phase), ep);
            check_val("R10", "burst_on", tag, int'(burst_on), int'(act));
            if (c == chg_cyc) begin
                ol_lvl = 5'(ol_new);
                cur_ol = ol_new;
            end
            last_code = ec;
        end
    endtask

    task automatic run_frame(input logic [7:0] m, input bit tm,
                             input int chg_slot, input int ol_new,
                             input string tag);
        for (int s = 0; s < 8; s++) begin
            run_slot(s, m, m, (s == 0), tm, (s == chg_slot) ? 10 : -1,
                     ol_new, tag);
        end
    endtask

    // R9: reset state, and mask ignored before a frame strobe
    task automatic t_reset();
        check_val("R9", "pwr_code", "reset", int'(pwr_code), OFFC);
        check_val("R9", "ramp_phase", "reset", int'(ramp_phase), 0);
        check_val("R9", "burst_on", "reset", int'(burst_on), 0);
        run_slot(0, 8'hFF, 8'h00, 1'b0, 1'b0, -1, 0, "R9 no frame strobe");
    endtask

    // R1 R4 R5 R7: isolated slot, each input limiting in turn
    task automatic t_single();
        set_levels(5, 12);
        run_frame(8'b0000_0100, 1'b0, -1, 0, "R1 open-loop limits");
        set_levels(14, 3);
        run_frame(8'b0000_0001, 1'b0, -1, 0, "R1 ceiling limits");
    endtask

    // R2 R6: forced pattern, ordinal restarts each frame
    task automatic t_test_mode();
        set_levels(4, 9);
        run_frame(8'b0000_1111, 1'b1, -1, 0, "R2 dense");
        run_frame(8'b1010_0000, 1'b1, -1, 0, "R2 sparse");
    endtask

    // R3 R6: mid-slot level change applied at the next boundary
    task automatic t_midslot();
        set_levels(2, 8);
        run_frame(8'b0000_0111, 1'b0, 1, 20, "R3 mid-slot change");
    endtask

    // R8 R7: full duty across frames, then empty frame forces a fall
    task automatic t_full();
        set_levels(3, 7);
        run_frame(8'hFF, 1'b0, -1, 0, "R8 full frame 1");
        run_frame(8'hFF, 1'b0, -1, 0, "R8 full frame 2");
        run_frame(8'h00, 1'b0, -1, 0, "R7 mask drop");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        n_chk      = 0;
        n_err      = 0;
        last_code  = OFFC;
        exp_ord    = 0;
        rst_n      = 1'b0;
        slot_strb  = 1'b0;
        frame_strb = 1'b0;
        slot_mask  = 8'h00;
        test_mode  = 1'b0;
        set_levels(0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_test_mode();
        t_midslot();
        t_full();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule